// File: doc/BRIEF.md
# Fork-Join Job Sequencer

This block is a controlling state machine that runs one job each time a trigger event is accepted. A job has two phases. In the first, a set of parallel workers (two by default) is started together. In the second, once every one of them has finished, a single dependent worker is started. The job ends when that worker finishes, and the sequencer then goes back to waiting for the next trigger. Trigger pulses that arrive while a job is running are dropped; they are not queued.

Each worker has a request/acknowledge pair. The sequencer raises a start request. The worker answers by raising its busy flag, and lowers busy when its work is done. A start request to a parallel worker is withdrawn as soon as that worker has been seen busy. A per-worker memory of "has been busy" lets the first phase end correctly even when a fast worker has already finished before a slow one has begun. The join request is held until the dependent worker is seen busy. Every output is decoded from registered state, so a decision sampled on one clock edge appears at the ports during the next cycle.

Top module: `fork_join_sequencer`

## Requirements
- R1: While idle, the sequencer stays idle with all start outputs low until `tick` is sampled high. A tick sampled high when idle makes every bit of `start_fork` high in the cycle after that edge.
- R2: The bits of `start_fork` rise together in the same cycle. None rises alone.
- R3: Bit i of `start_fork` goes low in the cycle after the edge at which `busy_fork[i]` is first sampled high during the fork phase. The other bits are unaffected.
- R4: The fork phase ends only once every parallel worker has been sampled busy at least once. This holds even if a worker has already finished before another has started. The sequencer then waits until every `busy_fork` bit is sampled low.
- R5: `start_join` rises in the cycle after the edge at which all `busy_fork` bits are first sampled low in the wait phase. It is never high together with any `start_fork` bit.
- R6: `start_join` stays high until `busy_join` is sampled high, and goes low in the following cycle.
- R7: The sequencer is idle again in the cycle after `busy_join` is sampled low. A tick sampled on the very next edge starts a new job.
- R8: A tick sampled on any edge from the cycle after acceptance up to and including the edge at which the job ends is ignored. No start output rises because of it.
- R9: Reset is synchronous and active low. In the cycle after `rst_n` is sampled low, all start outputs are low and any job in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Trigger event, one cycle or longer |
| busy_fork | input | N_FORK | Busy flags of the parallel workers |
| busy_join | input | 1 | Busy flag of the dependent worker |
| start_fork | output | N_FORK | Start requests to the parallel workers |
| start_join | output | 1 | Start request to the dependent worker |

## Verification
Every phase drives its own start pattern, so an illegal or misplaced state shows up at the start outputs in the cycle after the faulty transition. Some internal errors leave the start pattern unchanged at first. A seen-busy flag that never sets leaves a start bit high after its worker responded, visible one cycle after the busy edge. An early exit from the wait phase raises `start_join` while a parallel worker is still busy. A missed return to idle shows one cycle after the job's end, when the following tick fails to raise `start_fork`. Workers with separate start delays and run lengths place each of these edges at a known cycle, so the expected start pattern can be checked every cycle.

// File: rtl/seq_pkg.sv
// Shared types for the fork-join job sequencer.
// Assumes nothing beyond a single clock domain.
package seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FORK      = 3'd1,
        ST_FORK_WAIT = 3'd2,
        ST_JOIN      = 3'd3,
        ST_JOIN_WAIT = 3'd4
    } seq_state_e;

endpackage

// File: rtl/seq_seen_flag.sv
// Remembers that one parallel worker has raised busy during the fork phase.
// Assumes arm is high only while the fork phase lasts; the flag clears
// as soon as arm drops, so each job starts with a clean flag.
module seq_seen_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic busy,
    output logic seen,
    output logic done
);

    logic seen_q;

    // Sticky record of busy, held only while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= arm & (seen_q | busy);
        end
    end

    assign seen = seen_q;
    assign done = seen_q | busy;

endmodule

// File: rtl/seq_ctrl.sv
// Phase register and transition logic of the sequencer.
// Assumes fork_done is high once every parallel worker has been seen busy,
// and that workers lower busy only after having raised it.
module seq_ctrl
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       fork_done,
    input  logic       fork_any_busy,
    input  logic       busy_join,
    output seq_state_e state
);

    seq_state_e state_q;
    seq_state_e state_d;

    // Next phase from the current phase and the handshake inputs.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (tick)           state_d = ST_FORK;
            ST_FORK:      if (fork_done)      state_d = ST_FORK_WAIT;
            ST_FORK_WAIT: if (!fork_any_busy) state_d = ST_JOIN;
            ST_JOIN:      if (busy_join)      state_d = ST_JOIN_WAIT;
            ST_JOIN_WAIT: if (!busy_join)     state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // Phase register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/fork_join_sequencer.sv
// Fork-join job sequencer top. On an accepted tick it starts N_FORK
// parallel workers, waits until all of them have run and finished, then
// starts one dependent worker and waits for it before going idle.
// Assumes every worker answers a start request by raising busy within
// finite time and lowers busy only when its work is done.
module fork_join_sequencer
    import seq_pkg::*;
#(
    parameter int N_FORK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [N_FORK-1:0] busy_fork,
    input  logic              busy_join,
    output logic [N_FORK-1:0] start_fork,
    output logic              start_join
);

    localparam int FORK_W = N_FORK;

    seq_state_e         state_q;
    logic               in_fork;
    logic [FORK_W-1:0]  seen_vec;
    logic [FORK_W-1:0]  done_vec;

    assign in_fork = (state_q == ST_FORK);

    // One seen-busy flag per parallel worker.
    for (genvar gi = 0; gi < FORK_W; gi++) begin : g_seen
        seq_seen_flag u_seen (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (in_fork),
            .busy  (busy_fork[gi]),
            .seen  (seen_vec[gi]),
            .done  (done_vec[gi])
        );
    end

    seq_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .fork_done     (&done_vec),
        .fork_any_busy (|busy_fork),
        .busy_join     (busy_join),
        .state         (state_q)
    );

    // Start requests decoded from the registered phase and flags.
    always_comb begin
        start_fork = {FORK_W{in_fork}} & ~seen_vec;
        start_join = (state_q == ST_JOIN);
    end

endmodule

// File: rtl/seq_checker.sv
// Protocol checks for the fork-join job sequencer, bound to its top.
// Assumes the phase register is visible as st.
module seq_checker
    import seq_pkg::*;
#(
    parameter int N_FORK = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [N_FORK-1:0] busy_fork,
    input logic              busy_join,
    input logic [N_FORK-1:0] start_fork,
    input logic              start_join,
    input seq_state_e        st
);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !tick) |=> (st == ST_IDLE)); // R1

    AST_FORK_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        ((|start_fork) && !$past(|start_fork)) |-> (&start_fork)); // R2

    for (genvar gi = 0; gi < N_FORK; gi++) begin : g_drop
        AST_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (start_fork[gi] && busy_fork[gi]) |=> !start_fork[gi]); // R3
    end

    AST_JOIN_AFTER_FORK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_join) |-> ($past(busy_fork) == '0)); // R5

    AST_JOIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        start_join |-> (start_fork == '0)); // R5

    AST_JOIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_join && !busy_join) |=> start_join); // R6

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_JOIN_WAIT) |=> (st == ST_JOIN_WAIT || st == ST_IDLE)); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (start_fork == '0 && !start_join)); // R9

endmodule

bind fork_join_sequencer seq_checker #(.N_FORK(N_FORK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .busy_fork  (busy_fork),
    .busy_join  (busy_join),
    .start_fork (start_fork),
    .start_join (start_join),
    .st         (state_q)
);

// File: tb/fork_join_sequencer_test.sv
// Behavioural worker: after seeing start while idle it waits dly cycles,
// then holds busy for lat cycles (lat >= 1).
module tb_worker (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  int   dly,
    input  int   lat,
    output logic busy
);
    int   cnt;
    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; armed <= 1'b0; cnt <= 0;
        end else if (busy) begin
            if (cnt <= 1) busy <= 1'b0;
            else cnt <= cnt - 1;
        end else if (armed) begin
            if (cnt <= 1) begin armed <= 1'b0; busy <= 1'b1; cnt <= lat; end
            else cnt <= cnt - 1;
        end else if (start) begin
            if (dly == 0) begin busy <= 1'b1; cnt <= lat; end
            else begin armed <= 1'b1; cnt <= dly; end
        end
    end
endmodule

module fork_join_sequencer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] busy_fork;
    logic       busy_join;
    logic [1:0] start_fork;
    logic       start_join;
    int da = 0, la = 1, db = 0, lb = 1, dc = 0, lc = 1;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #4 clk = ~clk;

    fork_join_sequencer #(.N_FORK(2)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .busy_fork(busy_fork), .busy_join(busy_join),
        .start_fork(start_fork), .start_join(start_join)
    );

    tb_worker u_wa (.clk(clk), .rst_n(rst_n), .start(start_fork[0]), .dly(da), .lat(la), .busy(busy_fork[0]));
    tb_worker u_wb (.clk(clk), .rst_n(rst_n), .start(start_fork[1]), .dly(db), .lat(lb), .busy(busy_fork[1]));
    tb_worker u_wc (.clk(clk), .rst_n(rst_n), .start(start_join),    .dly(dc), .lat(lc), .busy(busy_join));

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction

    // Expected {start_join, start_fork} in cycle rel after the accepting edge.
    function automatic logic [2:0] exp_bits(int rel);
        int e;
        e = 2 + imax(da + la, db + lb);
        if (rel < 0) return 3'b000;
        return {(rel >= e && rel <= e + 1 + dc), (rel <= 1 + db), (rel <= 1 + da)};
    endfunction

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Columns: fork A delay/length, fork B delay/length, join delay/length,
    // extra tick edge (0 none, -1 the job's last edge).
    localparam int NV = 6;
    localparam int VEC [NV][7] = '{
        '{0, 1, 0, 1, 0, 1,  0},
        '{0, 3, 0, 5, 0, 2,  3},   // tick in wait phase: R8
        '{0, 1, 4, 2, 1, 3,  2},   // A done before B starts: R4
        '{3, 6, 0, 1, 2, 1, -1},   // tick on final edge: R8
        '{2, 2, 2, 2, 0, 4,  1},
        '{5, 1, 1, 7, 3, 2,  0}
    };

    // One job: tick sampled at edge 0, cycles 0..F+3 compared.
    task automatic run_job(int xt, bit chain);
        int e, f, xe;
        logic [2:0] ex;
        string tag;
        e  = 2 + imax(da + la, db + lb);
        f  = e + 2 + dc + lc;
        xe = (xt < 0) ? f : xt;
        if (chain) xe = f + 1;
        @(negedge clk); tick = 1'b1;
        for (int k = 0; k <= f + 3; k++) begin
            @(posedge clk); @(negedge clk);
            tick = (xe != 0 && k + 1 == xe);
            ex = exp_bits(k);
            if (chain && k >= f + 1) ex = ex | exp_bits(k - f - 1);
            if (k == 0) tag = "R1";
            else if (k <= 1 + imax(da, db)) tag = "R3";
            else if (k < e) tag = "R4";
            else if (k == e) tag = "R5";
            else if (k < f) tag = "R6";
            else if (chain) tag = "R7";
            else tag = "R8";
            check(tag, {start_join, start_fork}, ex);
        end
        if (chain) repeat (60) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", {start_join, start_fork}, 3'b000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", {start_join, start_fork}, 3'b000);   // idle, no tick

        for (int v = 0; v < NV; v++) begin
            da = VEC[v][0]; la = VEC[v][1]; db = VEC[v][2];
            lb = VEC[v][3]; dc = VEC[v][4]; lc = VEC[v][5];
            run_job(VEC[v][6], 1'b0);
        end

        // R7: tick on the edge right after the job ends is accepted.
        da = 1; la = 2; db = 0; lb = 3; dc = 0; lc = 2;
        run_job(0, 1'b1);

        // R9: reset in the middle of a job abandons it.
        da = 0; la = 8; db = 0; lb = 8; dc = 0; lc = 1;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check("R2", {start_join, start_fork}, 3'b011);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", {start_join, start_fork}, 3'b000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9", {start_join, start_fork}, 3'b000);
        run_job(0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule